// File: doc/BRIEF.md
# Time-Interleaved Add-Multiply-Add Datapath

This block computes `(a + b) * c + d` on unsigned operands and accepts a new operand set on every clock cycle. The multiply is the slow step, so it is built as `N` identical lanes, two by default. Each lane has its own first-stage register bank. The banks load in strict rotation, so the multiplier behind a bank has `N` full clock cycles to settle before its product is taken.

A phase counter runs on the single clock and supplies two things. It gives each bank its load enable, and it drives the selector that passes the finished lane's product, together with that lane's `d` and valid bit, into a second-stage register. The final adder lies between that register and the output register. The full-width result and its valid flag leave the block `N + 1` edges after the operands were sampled, which is three edges with the default settings.

All flops use an asynchronous active-low reset. Operands presented while reset is low are never captured.

Top module: `tma_datapath`

## Requirements
- R1: When `vld_o` is high, `res_o` equals `(a_i + b_i) * c_i + d_i` of the corresponding operand set, computed without truncation in `2*W+2` bits, including all-ones operands.
- R2: Operands sampled at a rising edge with `vld_i` high appear on `res_o`, with `vld_o` high, right after the third rising edge that follows (latency `N+1` edges, `N`=2).
- R3: Valid operand sets on consecutive cycles give results on consecutive cycles, in the same order, with no gap.
- R4: `vld_o` is high after a given edge exactly when a valid operand set was sampled `N+1` edges earlier; a cycle sampled with `vld_i` low yields `vld_o` low.
- R5: While `vld_o` is low, `res_o` keeps the value of the last valid result (0 after reset).
- R6: While `rst_ni` is low, `res_o` and `vld_o` are 0 and all banks are cleared. An operand set presented while `rst_ni` is low produces no result, also when reset is applied in the middle of a stream.
- R7: The phase advances by one each edge modulo `N`, and exactly one lane bank loads on each edge, so lanes load in rotation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| vld_i | input | 1 | Operand set valid |
| a_i | input | W | First addend |
| b_i | input | W | Second addend |
| c_i | input | W | Multiplier operand |
| d_i | input | W | Final addend |
| res_o | output | 2*W+2 | Result |
| vld_o | output | 1 | Result valid |

## Verification
On one edge, a lane's bank can reload with fresh operands while that same lane's settled product is captured into the second stage. An uninterrupted stream of valid operand sets makes this happen on every edge. The bench drives exactly such a stream, an exhaustive sweep of all operand values at W=4, and checks each output against the arithmetic value for the set sampled three edges earlier. Any overlap error shows up as a result that is wrong or out of order. A reset pulse in the middle of the stream and random gaps in `vld_i` check that discarded and empty slots never produce a result.

// File: rtl/tma_pkg.sv
package tma_pkg;
  function automatic int sel_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  function automatic int lat(input int n);
    return n + 1;
  endfunction
endpackage

// File: rtl/tma_phase.sv
module tma_phase #(
  parameter int N = 2,
  localparam int SELW = tma_pkg::sel_w(N)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  output logic [SELW-1:0] phase_o,
  output logic [N-1:0]    load_o
);
  logic [SELW-1:0] phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      phase_q <= '0;
    else if (phase_q == SELW'(N - 1)) phase_q <= '0;
    else                              phase_q <= phase_q + 1'b1;
  end

  for (genvar i = 0; i < N; i++) begin : g_dec
    assign load_o[i] = (phase_q == SELW'(i));
  end

  assign phase_o = phase_q;
endmodule

// File: rtl/tma_lane.sv
module tma_lane #(
  parameter int W = 8,
  localparam int SW = W + 1,
  localparam int PW = 2 * W + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ld_i,
  input  logic          vld_i,
  input  logic [W-1:0]  a_i,
  input  logic [W-1:0]  b_i,
  input  logic [W-1:0]  c_i,
  input  logic [W-1:0]  d_i,
  output logic          vld_o,
  output logic [PW-1:0] prod_o,
  output logic [W-1:0]  d_o
);
  logic [SW-1:0] sum_q;
  logic [W-1:0]  c_q, d_q;
  logic          vld_q;

  // bank holds for N cycles; multiplier below is a multicycle path
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sum_q <= '0;
      c_q   <= '0;
      d_q   <= '0;
      vld_q <= 1'b0;
    end else if (ld_i) begin
      sum_q <= SW'(a_i) + SW'(b_i);
      c_q   <= c_i;
      d_q   <= d_i;
      vld_q <= vld_i;
    end
  end

  assign prod_o = PW'(sum_q) * PW'(c_q);
  assign d_o    = d_q;
  assign vld_o  = vld_q;
endmodule

// File: rtl/tma_join.sv
module tma_join #(
  parameter int W = 8,
  parameter int N = 2,
  localparam int PW   = 2 * W + 1,
  localparam int RW   = 2 * W + 2,
  localparam int SELW = tma_pkg::sel_w(N)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [SELW-1:0] sel_i,
  input  logic            lane_vld_i  [N],
  input  logic [PW-1:0]   lane_prod_i [N],
  input  logic [W-1:0]    lane_d_i    [N],
  output logic [RW-1:0]   res_o,
  output logic            vld_o
);
  logic [PW-1:0] prod_q;
  logic [W-1:0]  d_q;
  logic          vld_q;
  logic [RW-1:0] res_q;
  logic          out_vld_q;

  // sel_i names the lane that loaded N edges ago and reloads now
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prod_q <= '0;
      d_q    <= '0;
      vld_q  <= 1'b0;
    end else begin
      prod_q <= lane_prod_i[sel_i];
      d_q    <= lane_d_i[sel_i];
      vld_q  <= lane_vld_i[sel_i];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_q     <= '0;
      out_vld_q <= 1'b0;
    end else begin
      out_vld_q <= vld_q;
      if (vld_q) res_q <= RW'(prod_q) + RW'(d_q);
    end
  end

  assign res_o = res_q;
  assign vld_o = out_vld_q;
endmodule

// File: rtl/tma_datapath.sv
module tma_datapath #(
  parameter int W = 8,
  parameter int N = 2,
  localparam int PW   = 2 * W + 1,
  localparam int RW   = 2 * W + 2,
  localparam int SELW = tma_pkg::sel_w(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          vld_i,
  input  logic [W-1:0]  a_i,
  input  logic [W-1:0]  b_i,
  input  logic [W-1:0]  c_i,
  input  logic [W-1:0]  d_i,
  output logic [RW-1:0] res_o,
  output logic          vld_o
);
  logic [SELW-1:0] phase_q;
  logic [N-1:0]    lane_ld;
  logic            lane_vld  [N];
  logic [PW-1:0]   lane_prod [N];
  logic [W-1:0]    lane_d    [N];

  tma_phase #(.N(N)) u_phase (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .phase_o (phase_q),
    .load_o  (lane_ld)
  );

  for (genvar i = 0; i < N; i++) begin : g_lane
    tma_lane #(.W(W)) u_lane (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .ld_i   (lane_ld[i]),
      .vld_i  (vld_i),
      .a_i    (a_i),
      .b_i    (b_i),
      .c_i    (c_i),
      .d_i    (d_i),
      .vld_o  (lane_vld[i]),
      .prod_o (lane_prod[i]),
      .d_o    (lane_d[i])
    );
  end

  tma_join #(.W(W), .N(N)) u_join (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sel_i       (phase_q),
    .lane_vld_i  (lane_vld),
    .lane_prod_i (lane_prod),
    .lane_d_i    (lane_d),
    .res_o       (res_o),
    .vld_o       (vld_o)
  );
endmodule

// File: rtl/tma_datapath_chk.sv
module tma_datapath_chk #(
  parameter int W = 8,
  parameter int N = 2,
  localparam int RW   = 2 * W + 2,
  localparam int SELW = tma_pkg::sel_w(N),
  localparam int LAT  = tma_pkg::lat(N)
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            vld_i,
  input logic [W-1:0]    a_i,
  input logic [W-1:0]    b_i,
  input logic [W-1:0]    c_i,
  input logic [W-1:0]    d_i,
  input logic [RW-1:0]   res_o,
  input logic            vld_o,
  input logic [SELW-1:0] phase,
  input logic [N-1:0]    lane_ld
);
  logic          v_pipe [LAT+1];
  logic [RW-1:0] r_pipe [LAT+1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i <= LAT; i++) begin
        v_pipe[i] <= 1'b0;
        r_pipe[i] <= '0;
      end
    end else begin
      v_pipe[0] <= vld_i;
      r_pipe[0] <= (RW'(a_i) + RW'(b_i)) * RW'(c_i) + RW'(d_i);
      for (int i = 1; i <= LAT; i++) begin
        v_pipe[i] <= v_pipe[i-1];
        r_pipe[i] <= r_pipe[i-1];
      end
    end
  end

  p_value_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_o |-> res_o == r_pipe[LAT]);

  // covers R4 and R6 too: inputs seen during reset never enter v_pipe
  p_latency_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_o == v_pipe[LAT]);

  p_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vld_o |-> $stable(res_o));

  p_one_load_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(lane_ld) == 1);

  p_phase_step_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> int'(phase) == (int'($past(phase)) + 1) % N);
endmodule

bind tma_datapath tma_datapath_chk #(.W(W), .N(N)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .vld_i   (vld_i),
  .a_i     (a_i),
  .b_i     (b_i),
  .c_i     (c_i),
  .d_i     (d_i),
  .res_o   (res_o),
  .vld_o   (vld_o),
  .phase   (phase_q),
  .lane_ld (lane_ld)
);

// File: tb/sim_tma_datapath.sv
module sim_tma_datapath;
  localparam int W  = 4;
  localparam int N  = 2;
  localparam int RW = 2 * W + 2;
  localparam int M  = (1 << W) - 1;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          vld_i = 1'b0;
  logic [W-1:0]  a_i = '0, b_i = '0, c_i = '0, d_i = '0;
  logic [RW-1:0] res_o;
  logic          vld_o;

  int total = 0;
  int bad = 0;
  bit ev [4];
  int er [4];
  int last = 0;

  always #10 clk_i = ~clk_i;

  tma_datapath #(.W(W), .N(N)) u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .vld_i(vld_i),
    .a_i(a_i), .b_i(b_i), .c_i(c_i), .d_i(d_i),
    .res_o(res_o), .vld_o(vld_o)
  );

  task automatic check_out(input string tag);
    bit ok;
    if (ev[3]) begin
      ok = vld_o === 1'b1 && int'(res_o) == er[3];
      if (!ok) $display("FAIL %s: vld_o=%0b res_o=%0d expected vld_o=1 res_o=%0d",
                        tag, vld_o, res_o, er[3]);
      last = er[3];
    end else begin
      ok = vld_o === 1'b0 && int'(res_o) == last;
      if (!ok) $display("FAIL %s: vld_o=%0b res_o=%0d expected vld_o=0 res_o=%0d",
                        tag, vld_o, res_o, last);
    end
    total++;
    if (!ok) bad++;
  endtask

  // one cycle: check result due now, then drive the next inputs at the falling edge
  task automatic step(input bit r, input bit v, input int a, input int b,
                      input int c, input int d, input string tag);
    @(negedge clk_i);
    check_out(tag);
    for (int i = 3; i > 0; i--) begin
      ev[i] = ev[i-1];
      er[i] = er[i-1];
    end
    rst_ni = r;
    vld_i  = v;
    a_i = W'(a); b_i = W'(b); c_i = W'(c); d_i = W'(d);
    ev[0] = v && r;
    er[0] = (a + b) * c + d;
    if (!r) begin
      for (int i = 0; i < 4; i++) ev[i] = 1'b0;
      last = 0;
    end
  endtask

  initial begin
    for (int i = 0; i < 4; i++) begin ev[i] = 1'b0; er[i] = 0; end
    // R6: valid operands held during reset are dropped, outputs stay 0
    for (int i = 0; i < 4; i++) step(1'b0, 1'b1, M, M, M, M, "R6");
    // release with valid asserted: first set counts, latency 3 (R2)
    for (int i = 0; i < 4; i++) step(1'b1, 1'b1, i, i + 1, i + 2, i + 3, "R2 R6");
    // R1 R3 R7: exhaustive back-to-back sweep, includes all-ones operands
    for (int a = 0; a <= M; a++)
      for (int b = 0; b <= M; b++)
        for (int c = 0; c <= M; c++)
          for (int d = 0; d <= M; d++)
            step(1'b1, 1'b1, a, b, c, d, "R1 R3 R7");
    // R4 R5: random gaps in the valid stream
    for (int i = 0; i < 2000; i++)
      step(1'b1, 1'($urandom_range(0, 2) == 0), $urandom_range(0, M),
           $urandom_range(0, M), $urandom_range(0, M), $urandom_range(0, M), "R2 R4 R5");
    // R6: reset pulse in mid-stream
    for (int k = 0; k < 3; k++) begin
      for (int i = 0; i < 5; i++)
        step(1'b1, 1'b1, $urandom_range(0, M), $urandom_range(0, M),
             $urandom_range(0, M), $urandom_range(0, M), "R6");
      for (int i = 0; i <= k; i++)
        step(1'b0, 1'b1, M, M, M, M, "R6");
    end
    for (int i = 0; i < 6; i++) step(1'b1, 1'b0, 0, 0, 0, 0, "R5 R6");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(150000 * 20);
    bad++;
    total++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule